// File: doc/BRIEF.md
# Multicast Hash Address Filter

This block decides whether a received Ethernet frame should be kept, based only on its 48-bit destination address. The address arrives one byte per cycle, first byte first. A 32-bit CRC runs over the bytes as they arrive. When the sixth byte has been taken, the six most significant CRC bits select one bit of a 64-bit hash table. The table is held as four 16-bit registers. One cycle later the block presents a keep/drop decision. Broadcast destinations are always kept, and so is every frame while promiscuous mode is on.

The host side loads the table through a builder. The host gives a request with an address count and two flags (all-multicast and promiscuous), then hands over the addresses one at a time. While an update is in progress, the builder holds the receive side off. It waits for any address already being hashed to finish, hashes each listed multicast address into a shadow image, and then commits the result to the live table in one cycle. When the update completes, the receiver is released again.

Top module: `mhf_filter`

## Requirements
- R1: After synchronous reset, `hash_tbl` is all zeros, `promisc_on` is 0, `dec_valid` is 0 and `upd_busy` is 0.
- R2: The hash index of an address is bits 31:26 of a CRC-32 computed as follows: reflected polynomial 0xEDB88320, register preset to all ones, no final inversion. Byte 0 is `addr[7:0]` and is fed first, and each byte is fed least significant bit first. Index bits 5:4 select table register k, which is `hash_tbl[16k+15:16k]`. Index bits 3:0 select the bit within that register. The flat bit position in `hash_tbl` is therefore the index itself.
- R3: A frame starts with `rx_first`=1 on its first byte and continues with consecutive `rx_valid` bytes. `dec_valid` is high for exactly the one cycle that follows the sixth address byte. For a multicast address (bit 0 of byte 0 is 1), `dec_accept` is 1 exactly when the hashed table bit is set. A unicast address is rejected.
- R4: The broadcast address (all six bytes 0xFF) is accepted whatever the table holds.
- R5: While `promisc_on` is 1, every decided frame is accepted, unicast included.
- R6: A list update with both flags clear replaces the table with the OR of the hashed bits of the listed addresses. Listed addresses whose byte 0 has bit 0 clear are skipped. The update also clears `promisc_on`.
- R7: An update that sets the all-multicast flag, or whose count exceeds 64, sets all four registers to 0xFFFF and clears `promisc_on`. A count of exactly 64 still builds the table from the list.
- R8: An update with only the promiscuous flag set sets `promisc_on` and leaves the table unchanged.
- R9: From the cycle after `upd_start` until `upd_busy` falls, `rx_active` is 0. An address already in flight completes and is decided against the old table. No list address is accepted (`upd_addr_ready` stays 0) until that address has finished. The table changes only while the receiver is off and idle.
- R10: A frame whose first byte arrives while `rx_active` is 0 produces no decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_rx_enable | input | 1 | Host request to run the receive filter |
| rx_valid | input | 1 | Address byte present on `rx_byte` |
| rx_first | input | 1 | Marks the first address byte of a frame |
| rx_byte | input | 8 | Destination address byte |
| upd_start | input | 1 | Pulse: begin a table update (ignored while busy) |
| upd_allmulti | input | 1 | Update flag: accept all multicast |
| upd_promisc | input | 1 | Update flag: promiscuous mode |
| upd_count | input | 8 | Number of list addresses that follow |
| upd_addr_valid | input | 1 | List address present on `upd_addr` |
| upd_addr | input | 48 | List address, byte 0 in bits 7:0 |
| upd_addr_ready | output | 1 | Builder takes `upd_addr` this cycle if valid |
| upd_busy | output | 1 | Update in progress |
| rx_active | output | 1 | Receive filter currently enabled |
| dec_valid | output | 1 | Decision strobe |
| dec_accept | output | 1 | Decision: 1 keep, 0 drop |
| promisc_on | output | 1 | Promiscuous flag |
| hash_tbl | output | 64 | Four 16-bit table registers, register k at bits 16k+15:16k |

## Verification
The bench targets the index split, the skip rule, the limit of 64 and timing.

- **Index split and byte order.** A design that swapped the register and bit select, or fed bytes most significant bit first, would set a different `hash_tbl` bit than the bench's own CRC predicts.
- **Skip rule.** A design that ignored the rule would light a bit for the unicast list entry.
- **The limit of 64.** The bench loads exactly 64 addresses and then 65. An off-by-one would fill the table too early or build it when it should fill.
- **Timing.** The bench starts an update in the middle of an incoming address. A design that did not wait for the receiver to go idle would take list addresses early. A design that did not gate new frames would issue decisions while the receiver is meant to be off.

// File: rtl/mhf_pkg.sv
package mhf_pkg;

    localparam int BYTE_W     = 8;
    localparam int ADDR_BYTES = 6;
    localparam int ADDR_W     = ADDR_BYTES * BYTE_W;
    localparam int CRC_W      = 32;
    localparam int IDX_W      = 6;
    localparam int SEL_W      = 2;
    localparam int BIT_W      = IDX_W - SEL_W;
    localparam int TBL_REGS   = 1 << SEL_W;
    localparam int REG_W      = 1 << BIT_W;
    localparam int TBL_W      = TBL_REGS * REG_W;
    localparam int BCNT_W     = $clog2(ADDR_BYTES + 1);

    localparam logic [CRC_W-1:0] CRC_POLY = 32'hEDB88320;
    localparam logic [CRC_W-1:0] CRC_INIT = '1;

    typedef logic [IDX_W-1:0] hidx_t;

    typedef enum logic [1:0] {
        BLD_IDLE,
        BLD_QUIESCE,
        BLD_COLLECT,
        BLD_COMMIT
    } bld_state_e;

    typedef enum logic [1:0] {
        TBL_KEEP,
        TBL_LOAD,
        TBL_FILL
    } tbl_op_e;

    typedef struct packed {
        tbl_op_e          op;
        logic             promisc;
        logic [TBL_W-1:0] image;
    } tbl_cmd_t;

    // Advance a reflected CRC by one byte, least significant bit first.
    function automatic logic [CRC_W-1:0] crc_step_byte(
        input logic [CRC_W-1:0]  crc_in,
        input logic [BYTE_W-1:0] data
    );
        logic [CRC_W-1:0] c;
        logic             fb;
        c = crc_in;
        for (int i = 0; i < BYTE_W; i++) begin
            fb = c[0] ^ data[i];
            c  = c >> 1;
            if (fb) c = c ^ CRC_POLY;
        end
        return c;
    endfunction

    // Hash index taken from the top bits of the CRC.
    function automatic hidx_t hidx_of(input logic [CRC_W-1:0] crc);
        return crc[CRC_W-1 -: IDX_W];
    endfunction

endpackage

// File: rtl/mhf_hash_table.sv
module mhf_hash_table
    import mhf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  tbl_cmd_t         cmd,
    input  hidx_t            lk_idx,
    output logic             lk_hit,
    output logic             promisc_on,
    output logic [TBL_W-1:0] tbl_flat
);

    logic promisc_q;

    // One 16-bit register per select value.
    for (genvar k = 0; k < TBL_REGS; k++) begin : g_reg
        logic [REG_W-1:0] word_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                word_q <= '0;
            end else if (cmd_valid) begin
                unique case (cmd.op)
                    TBL_FILL: word_q <= '1;
                    TBL_LOAD: word_q <= cmd.image[k*REG_W +: REG_W];
                    default:  word_q <= word_q;
                endcase
            end
        end

        assign tbl_flat[k*REG_W +: REG_W] = word_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            promisc_q <= 1'b0;
        end else if (cmd_valid) begin
            promisc_q <= cmd.promisc;
        end
    end

    assign promisc_on = promisc_q;
    assign lk_hit     = tbl_flat[lk_idx];

endmodule

// File: rtl/mhf_rx_hasher.sv
module mhf_rx_hasher
    import mhf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_active,
    input  logic              rx_valid,
    input  logic              rx_first,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              promisc,
    input  logic              lk_hit,
    output hidx_t             lk_idx,
    output logic              rx_idle,
    output logic              dec_valid,
    output logic              dec_accept
);

    localparam logic [BCNT_W-1:0] LAST_CNT = BCNT_W'(ADDR_BYTES - 1);

    logic [BCNT_W-1:0] cnt_q;
    logic [CRC_W-1:0]  crc_q;
    logic [CRC_W-1:0]  crc_n;
    logic              mcast_q;
    logic              bcast_q;
    logic              dec_valid_q;
    logic              dec_accept_q;

    logic take_first;
    logic take_next;
    logic last_byte;
    logic byte_ones;
    logic verdict;

    always_comb begin
        take_first = rx_valid & rx_first & rx_active;
        take_next  = rx_valid & ~rx_first & (cnt_q != '0);
        last_byte  = take_next & (cnt_q == LAST_CNT);
        byte_ones  = &rx_byte;
        crc_n      = crc_step_byte(take_first ? CRC_INIT : crc_q, rx_byte);
        lk_idx     = hidx_of(crc_n);
        verdict    = promisc | (bcast_q & byte_ones) | (mcast_q & lk_hit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q        <= '0;
            crc_q        <= CRC_INIT;
            mcast_q      <= 1'b0;
            bcast_q      <= 1'b0;
            dec_valid_q  <= 1'b0;
            dec_accept_q <= 1'b0;
        end else begin
            dec_valid_q  <= last_byte;
            dec_accept_q <= last_byte & verdict;
            if (take_first) begin
                cnt_q   <= BCNT_W'(1);
                crc_q   <= crc_n;
                mcast_q <= rx_byte[0];
                bcast_q <= byte_ones;
            end else if (rx_valid & rx_first) begin
                // New frame while the filter is off: drop any partial address.
                cnt_q <= '0;
            end else if (last_byte) begin
                cnt_q <= '0;
            end else if (take_next) begin
                cnt_q   <= cnt_q + BCNT_W'(1);
                crc_q   <= crc_n;
                bcast_q <= bcast_q & byte_ones;
            end
        end
    end

    assign rx_idle    = (cnt_q == '0);
    assign dec_valid  = dec_valid_q;
    assign dec_accept = dec_accept_q;

endmodule

// File: rtl/mhf_table_builder.sv
module mhf_table_builder
    import mhf_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int OVF_LIMIT = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              upd_start,
    input  logic              upd_allmulti,
    input  logic              upd_promisc,
    input  logic [CNT_W-1:0]  upd_count,
    input  logic              upd_addr_valid,
    input  logic [ADDR_W-1:0] upd_addr,
    input  logic              rx_idle,
    output logic              upd_addr_ready,
    output logic              upd_busy,
    output logic              rx_hold,
    output logic              cmd_valid,
    output tbl_cmd_t          cmd
);

    localparam logic [BCNT_W-1:0] LAST_BI = BCNT_W'(ADDR_BYTES - 1);
    localparam logic [CNT_W-1:0]  LIMIT   = CNT_W'(OVF_LIMIT);

    typedef struct packed {
        logic             allmulti;
        logic             promisc;
        logic [CNT_W-1:0] count;
    } upd_req_t;

    bld_state_e        state_q;
    upd_req_t          req_q;
    logic [CNT_W-1:0]  left_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CRC_W-1:0]  crc_q;
    logic [BCNT_W-1:0] bi_q;
    logic              hashing_q;
    logic [TBL_W-1:0]  shadow_q;

    logic [CRC_W-1:0]  crc_n;
    logic [BYTE_W-1:0] byte_in;
    hidx_t             idx_n;
    logic              take_addr;
    logic              overflow;

    always_comb begin
        byte_in   = hashing_q ? addr_q[{bi_q, 3'b000} +: BYTE_W] : upd_addr[BYTE_W-1:0];
        crc_n     = crc_step_byte(hashing_q ? crc_q : CRC_INIT, byte_in);
        idx_n     = hidx_of(crc_n);
        take_addr = (state_q == BLD_COLLECT) & ~hashing_q & upd_addr_valid;
        overflow  = (req_q.count > LIMIT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= BLD_IDLE;
            req_q     <= '0;
            left_q    <= '0;
            addr_q    <= '0;
            crc_q     <= CRC_INIT;
            bi_q      <= '0;
            hashing_q <= 1'b0;
            shadow_q  <= '0;
        end else begin
            unique case (state_q)
                BLD_IDLE: begin
                    if (upd_start) begin
                        req_q    <= '{allmulti: upd_allmulti, promisc: upd_promisc, count: upd_count};
                        left_q   <= upd_count;
                        shadow_q <= '0;
                        state_q  <= BLD_QUIESCE;
                    end
                end
                BLD_QUIESCE: begin
                    if (rx_idle) begin
                        state_q <= (left_q == '0) ? BLD_COMMIT : BLD_COLLECT;
                    end
                end
                BLD_COLLECT: begin
                    if (take_addr) begin
                        addr_q    <= upd_addr;
                        crc_q     <= crc_n;
                        bi_q      <= BCNT_W'(1);
                        hashing_q <= 1'b1;
                    end else if (hashing_q) begin
                        crc_q <= crc_n;
                        if (bi_q == LAST_BI) begin
                            hashing_q <= 1'b0;
                            if (addr_q[0]) shadow_q[idx_n] <= 1'b1;
                            left_q <= left_q - CNT_W'(1);
                            if (left_q == CNT_W'(1)) state_q <= BLD_COMMIT;
                        end else begin
                            bi_q <= bi_q + BCNT_W'(1);
                        end
                    end
                end
                BLD_COMMIT: begin
                    state_q <= BLD_IDLE;
                end
                default: state_q <= BLD_IDLE;
            endcase
        end
    end

    always_comb begin
        cmd_valid   = (state_q == BLD_COMMIT);
        cmd.image   = shadow_q;
        if (req_q.allmulti | overflow) begin
            cmd.op      = TBL_FILL;
            cmd.promisc = 1'b0;
        end else if (req_q.promisc) begin
            cmd.op      = TBL_KEEP;
            cmd.promisc = 1'b1;
        end else begin
            cmd.op      = TBL_LOAD;
            cmd.promisc = 1'b0;
        end
    end

    assign upd_addr_ready = (state_q == BLD_COLLECT) & ~hashing_q;
    assign upd_busy       = (state_q != BLD_IDLE);
    assign rx_hold        = (state_q != BLD_IDLE);

endmodule

// File: rtl/mhf_filter.sv
module mhf_filter
    import mhf_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int OVF_LIMIT = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_rx_enable,
    input  logic              rx_valid,
    input  logic              rx_first,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              upd_start,
    input  logic              upd_allmulti,
    input  logic              upd_promisc,
    input  logic [CNT_W-1:0]  upd_count,
    input  logic              upd_addr_valid,
    input  logic [ADDR_W-1:0] upd_addr,
    output logic              upd_addr_ready,
    output logic              upd_busy,
    output logic              rx_active,
    output logic              dec_valid,
    output logic              dec_accept,
    output logic              promisc_on,
    output logic [TBL_W-1:0]  hash_tbl
);

    logic     rx_hold_w;
    logic     rx_idle_w;
    logic     lk_hit_w;
    hidx_t    lk_idx_w;
    logic     cmd_valid_w;
    tbl_cmd_t cmd_w;

    assign rx_active = host_rx_enable & ~rx_hold_w;

    mhf_rx_hasher u_rx (
        .clk        (clk),
        .rst        (rst),
        .rx_active  (rx_active),
        .rx_valid   (rx_valid),
        .rx_first   (rx_first),
        .rx_byte    (rx_byte),
        .promisc    (promisc_on),
        .lk_hit     (lk_hit_w),
        .lk_idx     (lk_idx_w),
        .rx_idle    (rx_idle_w),
        .dec_valid  (dec_valid),
        .dec_accept (dec_accept)
    );

    mhf_table_builder #(
        .CNT_W     (CNT_W),
        .OVF_LIMIT (OVF_LIMIT)
    ) u_bld (
        .clk            (clk),
        .rst            (rst),
        .upd_start      (upd_start),
        .upd_allmulti   (upd_allmulti),
        .upd_promisc    (upd_promisc),
        .upd_count      (upd_count),
        .upd_addr_valid (upd_addr_valid),
        .upd_addr       (upd_addr),
        .rx_idle        (rx_idle_w),
        .upd_addr_ready (upd_addr_ready),
        .upd_busy       (upd_busy),
        .rx_hold        (rx_hold_w),
        .cmd_valid      (cmd_valid_w),
        .cmd            (cmd_w)
    );

    mhf_hash_table u_tbl (
        .clk        (clk),
        .rst        (rst),
        .cmd_valid  (cmd_valid_w),
        .cmd        (cmd_w),
        .lk_idx     (lk_idx_w),
        .lk_hit     (lk_hit_w),
        .promisc_on (promisc_on),
        .tbl_flat   (hash_tbl)
    );

endmodule

// File: rtl/mhf_filter_chk.sv
module mhf_filter_chk
    import mhf_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             rx_valid,
    input logic             rx_active,
    input logic             rx_idle,
    input logic             upd_addr_ready,
    input logic             upd_busy,
    input logic             dec_valid,
    input logic             dec_accept,
    input logic             promisc_on,
    input logic [TBL_W-1:0] hash_tbl
);

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (hash_tbl == '0 && !promisc_on && !dec_valid && !upd_busy));

    assert_dec_follows_byte_R3: assert property (@(posedge clk) disable iff (rst)
        dec_valid |-> $past(rx_valid));

    assert_dec_single_cycle_R3: assert property (@(posedge clk) disable iff (rst)
        dec_valid |=> !dec_valid);

    assert_promisc_accepts_R5: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && $past(promisc_on)) |-> dec_accept);

    assert_ready_within_update_R6: assert property (@(posedge clk) disable iff (rst)
        upd_addr_ready |-> (upd_busy && !rx_active && rx_idle));

    assert_table_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !$stable(hash_tbl) |-> $past(rx_idle && !rx_active));

    assert_off_stays_idle_R10: assert property (@(posedge clk) disable iff (rst)
        (rx_idle && !rx_active) |=> rx_idle);

endmodule

bind mhf_filter mhf_filter_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .rx_valid       (rx_valid),
    .rx_active      (rx_active),
    .rx_idle        (rx_idle_w),
    .upd_addr_ready (upd_addr_ready),
    .upd_busy       (upd_busy),
    .dec_valid      (dec_valid),
    .dec_accept     (dec_accept),
    .promisc_on     (promisc_on),
    .hash_tbl       (hash_tbl)
);

// File: tb/mhf_filter_tb_top.sv
module mhf_filter_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_rx_enable = 1'b1;
    logic        rx_valid = 1'b0;
    logic        rx_first = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        upd_start = 1'b0;
    logic        upd_allmulti = 1'b0;
    logic        upd_promisc = 1'b0;
    logic [7:0]  upd_count = '0;
    logic        upd_addr_valid = 1'b0;
    logic [47:0] upd_addr = '0;
    logic        upd_addr_ready;
    logic        upd_busy;
    logic        rx_active;
    logic        dec_valid;
    logic        dec_accept;
    logic        promisc_on;
    logic [63:0] hash_tbl;

    int checks = 0;
    int errors = 0;

    logic [47:0] alist [0:79];

    always #10 clk = ~clk;

    mhf_filter dut_i (
        .clk            (clk),
        .rst            (rst),
        .host_rx_enable (host_rx_enable),
        .rx_valid       (rx_valid),
        .rx_first       (rx_first),
        .rx_byte        (rx_byte),
        .upd_start      (upd_start),
        .upd_allmulti   (upd_allmulti),
        .upd_promisc    (upd_promisc),
        .upd_count      (upd_count),
        .upd_addr_valid (upd_addr_valid),
        .upd_addr       (upd_addr),
        .upd_addr_ready (upd_addr_ready),
        .upd_busy       (upd_busy),
        .rx_active      (rx_active),
        .dec_valid      (dec_valid),
        .dec_accept     (dec_accept),
        .promisc_on     (promisc_on),
        .hash_tbl       (hash_tbl)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [5:0] ref_idx(input logic [47:0] a);
        logic [31:0] c;
        logic        fb;
        c = 32'hFFFFFFFF;
        for (int b = 0; b < 48; b++) begin
            fb = c[0] ^ a[b];
            c  = c >> 1;
            if (fb) c = c ^ 32'hEDB88320;
        end
        return c[31:26];
    endfunction

    function automatic logic [63:0] ref_tbl(input int n);
        logic [63:0] t;
        t = '0;
        for (int i = 0; i < n; i++) begin
            if (alist[i][0]) t[ref_idx(alist[i])] = 1'b1;
        end
        return t;
    endfunction

    task automatic send_addr(input logic [47:0] a, output logic v, output logic acc);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_first = (k == 0);
            rx_byte  = a[8*k +: 8];
        end
        @(negedge clk);
        rx_valid = 1'b0;
        rx_first = 1'b0;
        v   = dec_valid;
        acc = dec_accept;
        @(negedge clk);
        chk(!dec_valid, "R3", "strobe lasts one cycle", {63'd0, dec_valid}, 64'd0);
    endtask

    task automatic load_tbl(input bit am, input bit pm, input int n);
        @(negedge clk);
        upd_start    = 1'b1;
        upd_allmulti = am;
        upd_promisc  = pm;
        upd_count    = 8'(n);
        @(negedge clk);
        upd_start = 1'b0;
        for (int i = 0; i < n; i++) begin
            while (!upd_addr_ready) @(negedge clk);
            upd_addr_valid = 1'b1;
            upd_addr       = alist[i];
            @(negedge clk);
            upd_addr_valid = 1'b0;
        end
        while (upd_busy) @(negedge clk);
    endtask

    logic [47:0] addr_a;
    logic [47:0] addr_b;
    logic [47:0] addr_u;
    localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;

    task automatic t_reset;
        chk(hash_tbl == '0, "R1", "table after reset", hash_tbl, 64'd0);
        chk(!promisc_on && !dec_valid && !upd_busy, "R1", "flags after reset",
            {61'd0, promisc_on, dec_valid, upd_busy}, 64'd0);
        chk(rx_active, "R1", "rx_active after reset", {63'd0, rx_active}, 64'd1);
    endtask

    task automatic t_list_build;
        logic [63:0] exp;
        alist[0] = addr_a;
        alist[1] = addr_u;
        exp = 64'd1 << ref_idx(addr_a);
        load_tbl(1'b0, 1'b0, 2);
        chk(hash_tbl == exp, "R2", "table bit from index; R6 unicast skipped", hash_tbl, exp);
        chk(!promisc_on, "R6", "promisc clear", {63'd0, promisc_on}, 64'd0);
    endtask

    task automatic t_rx_decisions;
        logic v, acc;
        send_addr(addr_a, v, acc);
        chk(v && acc, "R3", "listed multicast accepted", {62'd0, v, acc}, 64'd3);
        send_addr(addr_b, v, acc);
        chk(v && !acc, "R3", "unlisted multicast rejected", {62'd0, v, acc}, 64'd2);
        send_addr(addr_u, v, acc);
        chk(v && !acc, "R3", "unicast rejected", {62'd0, v, acc}, 64'd2);
        send_addr(BCAST, v, acc);
        chk(v && acc, "R4", "broadcast accepted", {62'd0, v, acc}, 64'd3);
    endtask

    task automatic t_allmulti;
        logic v, acc;
        alist[0] = addr_a;
        load_tbl(1'b1, 1'b0, 1);
        chk(hash_tbl == '1, "R7", "allmulti fills table", hash_tbl, '1);
        send_addr(addr_b, v, acc);
        chk(v && acc, "R7", "any multicast accepted after fill", {62'd0, v, acc}, 64'd3);
    endtask

    task automatic t_limit;
        logic [63:0] exp;
        for (int i = 0; i < 65; i++) alist[i] = 48'h0000_5E00_0001 | (48'(i) << 40);
        exp = ref_tbl(64);
        load_tbl(1'b0, 1'b0, 64);
        chk(hash_tbl == exp, "R7", "exactly 64 builds from list", hash_tbl, exp);
        load_tbl(1'b0, 1'b0, 65);
        chk(hash_tbl == '1, "R7", "65 addresses fill table", hash_tbl, '1);
    endtask

    task automatic t_promisc;
        logic [63:0] exp;
        logic        v, acc;
        alist[0] = addr_a;
        exp = 64'd1 << ref_idx(addr_a);
        load_tbl(1'b0, 1'b0, 1);
        load_tbl(1'b0, 1'b1, 0);
        chk(promisc_on, "R8", "promisc set", {63'd0, promisc_on}, 64'd1);
        chk(hash_tbl == exp, "R8", "table unchanged by promisc", hash_tbl, exp);
        send_addr(addr_u, v, acc);
        chk(v && acc, "R5", "unicast accepted in promisc", {62'd0, v, acc}, 64'd3);
        load_tbl(1'b0, 1'b0, 1);
        chk(!promisc_on, "R6", "list update clears promisc", {63'd0, promisc_on}, 64'd0);
    endtask

    task automatic t_quiesce;
        logic [63:0] exp;
        logic        v, acc;
        alist[0] = addr_b;
        exp = 64'd1 << ref_idx(addr_b);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            rx_valid  = 1'b1;
            rx_first  = (k == 0);
            rx_byte   = addr_a[8*k +: 8];
            upd_start = (k == 3);
            upd_count = 8'd1;
            upd_allmulti = 1'b0;
            upd_promisc  = 1'b0;
            if (k == 4) chk(!rx_active, "R9", "receiver off during update", {63'd0, rx_active}, 64'd0);
            if (k >= 4) chk(!upd_addr_ready, "R9", "no list intake while address in flight",
                            {63'd0, upd_addr_ready}, 64'd0);
        end
        @(negedge clk);
        upd_start = 1'b0;
        rx_valid  = 1'b0;
        rx_first  = 1'b0;
        v   = dec_valid;
        acc = dec_accept;
        chk(v && acc, "R9", "in-flight address uses old table", {62'd0, v, acc}, 64'd3);
        // A frame offered while the update holds the receiver off.
        send_addr(BCAST, v, acc);
        chk(!v, "R10", "no decision while update holds receiver", {63'd0, v}, 64'd0);
        while (!upd_addr_ready) @(negedge clk);
        upd_addr_valid = 1'b1;
        upd_addr       = alist[0];
        @(negedge clk);
        upd_addr_valid = 1'b0;
        while (upd_busy) @(negedge clk);
        chk(hash_tbl == exp, "R9", "new table after update", hash_tbl, exp);
        chk(rx_active, "R9", "receiver re-enabled", {63'd0, rx_active}, 64'd1);
        send_addr(addr_a, v, acc);
        chk(v && !acc, "R9", "old entry gone after update", {62'd0, v, acc}, 64'd2);
    endtask

    task automatic t_rx_off;
        logic v, acc;
        host_rx_enable = 1'b0;
        send_addr(BCAST, v, acc);
        chk(!v, "R10", "no decision with host enable low", {63'd0, v}, 64'd0);
        host_rx_enable = 1'b1;
        send_addr(BCAST, v, acc);
        chk(v && acc, "R10", "decisions resume when enabled", {62'd0, v, acc}, 64'd3);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        addr_a = 48'h0000_5E00_0001;
        addr_u = 48'h0000_5E00_0002;
        addr_b = 48'h0000_5E00_0001;
        for (int i = 1; i < 256; i++) begin
            addr_b = 48'h0000_5E00_0001 | (48'(i) << 40);
            if (ref_idx(addr_b) != ref_idx(addr_a)) break;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_list_build();
        t_rx_decisions();
        t_allmulti();
        t_limit();
        t_promisc();
        t_quiesce();
        t_rx_off();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule